// File: doc/BRIEF.md
# Validated Message DMA Arbiter

This block sits between a small message buffer and the main RAM of a serial-bus terminal. When the protocol logic reports that a message has been fully validated, the block drives an active-low message strobe for a fixed window. When that window closes, it runs a paced, word-by-word DMA burst between the buffer and RAM. A receive message moves words from the buffer into RAM. A transmit message moves words from RAM into the buffer. A message that fails validation never raises the validated pulse, so its buffered data is dropped and never reaches RAM.

While the strobe and the burst are running, the block also arbitrates subsystem access to the RAM:

- A subsystem cycle already requested when the strobe starts gets a short acknowledge pulse. It must finish inside the strobe window.
- A request that appears after the strobe has begun is held off until the burst is over.
- Outside these windows, a request is acknowledged on the next cycle.

Default timing assumes a 16 MHz clock:

- strobe: 136 cycles (8.5 us)
- grace acknowledge: 8 cycles (500 ns)
- word pacing: 16 cycles (1 us per word)
- words per message: up to 32

The grace window must be shorter than the strobe window, and the word limit must be a power of two.

Top module: `msgdma_arbiter`

## Requirements
- R1: A high `msg_ok_i` sampled while the block is idle is accepted. `msg_stb_no` is then low for exactly STROBE_CYC cycles, starting the cycle after the accepting edge.
- R2: The burst starts in the first cycle after the strobe returns high. Word j has its enables high for exactly one cycle, STROBE_CYC + j*WORD_CYC + 1 cycles after the accepting edge. The enables are low in every other burst cycle.
- R3: If `sub_req_i` is high at the accepting edge, `sub_ack_no` is low for the first ACK_CYC cycles of the strobe and then goes high.
- R4: Apart from that grace pulse, `sub_ack_no` stays high from the accepting edge until the last burst cycle, whatever `sub_req_i` does.
- R5: The burst moves N words, where N is `wcount_i` and a field value of 0 means MAX_WORDS. Both `buf_addr_o` and `ram_addr_o` carry the word index, which runs 0, 1, …, N-1.
- R6: With `dir_rx_i`=1 (receive), each word raises `buf_rd_o` and `ram_wr_o` together. With `dir_rx_i`=0 (transmit), each word raises `ram_rd_o` and `buf_wr_o` together. The other pair stays low.
- R7: Without an accepted `msg_ok_i`, the block gives no strobe, no enables and no busy indication (a failed message is flushed).
- R8: While idle, `sub_ack_no` is the inverse of `sub_req_i` delayed by one cycle. If the request is held over the end of a burst, the acknowledge goes low in the first cycle after the last burst cycle.
- R9: `busy_o` is high from the first strobe cycle through the last burst cycle. After reset, `busy_o`=0, `msg_stb_no`=1, `sub_ack_no`=1 and all enables are 0.
- R10: A `msg_ok_i` pulse while `busy_o` is high is ignored. No second strobe or burst follows.
- R11: `wcount_i` and `dir_rx_i` are captured at the accepting edge. Later changes to them have no effect on the running message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (16 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_ok_i | input | 1 | Message fully validated, one-cycle pulse |
| wcount_i | input | $clog2(MAX_WORDS) | Word count, 0 = MAX_WORDS |
| dir_rx_i | input | 1 | 1 = receive (buffer to RAM), 0 = transmit (RAM to buffer) |
| sub_req_i | input | 1 | Subsystem RAM access request, level |
| msg_stb_no | output | 1 | Message strobe, active low |
| sub_ack_no | output | 1 | Subsystem acknowledge, active low |
| buf_addr_o | output | $clog2(MAX_WORDS) | Buffer word address during the burst |
| ram_addr_o | output | $clog2(MAX_WORDS) | RAM word offset during the burst |
| buf_rd_o | output | 1 | Buffer read enable |
| buf_wr_o | output | 1 | Buffer write enable |
| ram_rd_o | output | 1 | RAM read enable |
| ram_wr_o | output | 1 | RAM write enable |
| busy_o | output | 1 | Strobe or burst in progress |

## Verification
Every result is counted from the accepting edge t=0:

- The strobe is low for cycles 1 through STROBE_CYC.
- Word j pulses its enables at cycle STROBE_CYC + j*WORD_CYC + 1.
- Busy ends after cycle STROBE_CYC + N*WORD_CYC.
- A grace acknowledge occupies cycles 1 through ACK_CYC.
- An idle acknowledge follows its request by one cycle.

The bench drives inputs on falling edges and samples on the next falling edge. It recomputes every output for each cycle index t from these formulas, over all word counts, both directions and three request patterns. It scrambles the word count and direction after acceptance, and in some runs injects a second validated pulse during the burst.

// File: rtl/msgdma_pkg.sv
package msgdma_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STROBE = 2'd1,
        SEQ_MOVE   = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        ARB_OPEN  = 2'd0,
        ARB_GRACE = 2'd1,
        ARB_HOLD  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/msgdma_seq.sv
module msgdma_seq
    import msgdma_pkg::*;
#(
    parameter int STROBE_CYC = 136,
    parameter int WORD_CYC   = 16,
    parameter int MAX_WORDS  = 32,
    localparam int AW   = $clog2(MAX_WORDS),
    localparam int CMAX = (STROBE_CYC > WORD_CYC) ? STROBE_CYC : WORD_CYC,
    localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          msg_ok_i,
    input  logic [AW-1:0] wcount_i,
    input  logic          dir_rx_i,
    output logic          start_o,
    output logic          done_o,
    output logic          strobe_o,
    output logic          moving_o,
    output logic          xfer_o,
    output logic          dir_o,
    output logic [AW-1:0] idx_o
);

    localparam logic [CW-1:0] STB_LAST  = CW'(STROBE_CYC - 1);
    localparam logic [CW-1:0] WORD_LAST = CW'(WORD_CYC - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] idx;
        logic [AW-1:0] last;
        logic          dir;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        start_o = 1'b0;
        done_o  = 1'b0;
        case (q.state)
            SEQ_IDLE: begin
                if (msg_ok_i) begin
                    d.state = SEQ_STROBE;
                    d.cnt   = STB_LAST;
                    d.idx   = '0;
                    d.last  = wcount_i - 1'b1;   // field 0 wraps to MAX_WORDS-1
                    d.dir   = dir_rx_i;
                    start_o = 1'b1;
                end
            end
            SEQ_STROBE: begin
                if (q.cnt == '0) begin
                    d.state = SEQ_MOVE;
                    d.cnt   = WORD_LAST;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SEQ_MOVE: begin
                if (q.cnt == '0) begin
                    if (q.idx == q.last) begin
                        d.state = SEQ_IDLE;
                        done_o  = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.cnt = WORD_LAST;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state <= SEQ_IDLE;
            q.cnt   <= '0;
            q.idx   <= '0;
            q.last  <= '0;
            q.dir   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign strobe_o = (q.state == SEQ_STROBE);
    assign moving_o = (q.state == SEQ_MOVE);
    assign xfer_o   = moving_o && (q.cnt == WORD_LAST);
    assign dir_o    = q.dir;
    assign idx_o    = q.idx;

    // R1: the strobe only begins after an accepted validated pulse
    assert_strobe_needs_ok_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(strobe_o) |-> $past(msg_ok_i));

    // R2: the first word moves right after the last strobe cycle
    assert_burst_follows_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == SEQ_STROBE && q.cnt == '0) |=> xfer_o);

    // R5: no word beyond the captured count is ever moved
    assert_index_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_o |-> (idx_o <= q.last));

endmodule

// File: rtl/msgdma_arb.sv
module msgdma_arb
    import msgdma_pkg::*;
#(
    parameter int ACK_CYC = 8,
    localparam int KW = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic done_i,
    input  logic sub_req_i,
    output logic ack_no
);

    localparam logic [KW-1:0] ACK_LAST = KW'(ACK_CYC - 1);

    typedef struct packed {
        arb_state_e    mode;
        logic [KW-1:0] cnt;
        logic          ack_n;
    } arb_t;

    arb_t q, d;

    always_comb begin
        d = q;
        case (q.mode)
            ARB_OPEN: begin
                d.ack_n = ~sub_req_i;
                if (start_i) begin
                    if (sub_req_i) begin
                        d.mode  = ARB_GRACE;
                        d.cnt   = ACK_LAST;
                        d.ack_n = 1'b0;
                    end else begin
                        d.mode  = ARB_HOLD;
                        d.ack_n = 1'b1;
                    end
                end
            end
            ARB_GRACE: begin
                if (q.cnt == '0) begin
                    d.mode  = ARB_HOLD;
                    d.ack_n = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ARB_HOLD: begin
                d.ack_n = 1'b1;
                if (done_i) begin
                    d.mode  = ARB_OPEN;
                    d.ack_n = ~sub_req_i;
                end
            end
            default: d.mode = ARB_OPEN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.mode  <= ARB_OPEN;
            q.cnt   <= '0;
            q.ack_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ack_no = q.ack_n;

    // R3: a request standing at the strobe start is acknowledged in the next cycle
    assert_grace_granted_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && sub_req_i) |=> !ack_no);

    // R4: a request absent at the strobe start gets no acknowledge
    assert_late_request_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !sub_req_i) |=> ack_no);

endmodule

// File: rtl/msgdma_arbiter.sv
module msgdma_arbiter #(
    parameter int STROBE_CYC = 136,
    parameter int ACK_CYC    = 8,
    parameter int WORD_CYC   = 16,
    parameter int MAX_WORDS  = 32,
    localparam int AW = $clog2(MAX_WORDS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          msg_ok_i,
    input  logic [AW-1:0] wcount_i,
    input  logic          dir_rx_i,
    input  logic          sub_req_i,
    output logic          msg_stb_no,
    output logic          sub_ack_no,
    output logic [AW-1:0] buf_addr_o,
    output logic [AW-1:0] ram_addr_o,
    output logic          buf_rd_o,
    output logic          buf_wr_o,
    output logic          ram_rd_o,
    output logic          ram_wr_o,
    output logic          busy_o
);

    logic          start, done, strobe, moving, xfer, dir;
    logic [AW-1:0] idx;

    msgdma_seq #(
        .STROBE_CYC (STROBE_CYC),
        .WORD_CYC   (WORD_CYC),
        .MAX_WORDS  (MAX_WORDS)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .msg_ok_i (msg_ok_i),
        .wcount_i (wcount_i),
        .dir_rx_i (dir_rx_i),
        .start_o  (start),
        .done_o   (done),
        .strobe_o (strobe),
        .moving_o (moving),
        .xfer_o   (xfer),
        .dir_o    (dir),
        .idx_o    (idx)
    );

    msgdma_arb #(
        .ACK_CYC (ACK_CYC)
    ) u_arb (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .done_i    (done),
        .sub_req_i (sub_req_i),
        .ack_no    (sub_ack_no)
    );

    assign msg_stb_no = ~strobe;
    assign busy_o     = strobe | moving;
    assign buf_addr_o = idx;
    assign ram_addr_o = idx;
    assign buf_rd_o   = xfer & dir;
    assign ram_wr_o   = xfer & dir;
    assign ram_rd_o   = xfer & ~dir;
    assign buf_wr_o   = xfer & ~dir;

    // R4: during the burst the subsystem is never acknowledged
    assert_burst_locks_subsystem_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && msg_stb_no) |-> sub_ack_no);

    // R7: an idle block touches neither memory
    assert_idle_no_traffic_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !(buf_rd_o || buf_wr_o || ram_rd_o || ram_wr_o || !msg_stb_no));

    // R8: an idle request held for a cycle is acknowledged
    assert_idle_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && $past(!busy_o) && $past(sub_req_i)) |-> !sub_ack_no);

endmodule

// File: tb/msgdma_arbiter_bench.sv
module msgdma_arbiter_bench;

    localparam int STB  = 12;
    localparam int ACK  = 3;
    localparam int W    = 4;
    localparam int MAXW = 8;
    localparam int AW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msg_ok = 1'b0;
    logic [AW-1:0] wcount = '0;
    logic          dir_rx = 1'b0;
    logic          sub_req = 1'b0;
    logic          stb_n, ack_n, busy;
    logic [AW-1:0] baddr, raddr;
    logic          brd, bwr, rrd, rwr;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    msgdma_arbiter #(
        .STROBE_CYC (STB),
        .ACK_CYC    (ACK),
        .WORD_CYC   (W),
        .MAX_WORDS  (MAXW)
    ) u_msgdma_arbiter (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .msg_ok_i   (msg_ok),
        .wcount_i   (wcount),
        .dir_rx_i   (dir_rx),
        .sub_req_i  (sub_req),
        .msg_stb_no (stb_n),
        .sub_ack_no (ack_n),
        .buf_addr_o (baddr),
        .ram_addr_o (raddr),
        .buf_rd_o   (brd),
        .buf_wr_o   (bwr),
        .ram_rd_o   (rrd),
        .ram_wr_o   (rwr),
        .busy_o     (busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int en_bits();
        return {28'd0, brd, bwr, rrd, rwr};
    endfunction

    // req_mode: 0 none, 1 held from before acceptance, 2 raised mid-strobe
    task automatic run_msg(input int wc, input bit dir, input int req_mode, input bit extra);
        int n, fin, seen;
        n    = (wc == 0) ? MAXW : wc;
        fin  = STB + n * W;
        seen = 0;
        @(negedge clk);
        msg_ok  = 1'b1;
        wcount  = AW'(wc);
        dir_rx  = dir;
        sub_req = (req_mode == 1);
        for (int t = 1; t <= fin + 2; t++) begin
            int m, exp_en, exp_ack;
            bit slot;
            @(negedge clk);
            m      = t - STB - 1;
            slot   = (t > STB) && (t <= fin) && (m % W == 0);
            exp_en = slot ? (dir ? 4'b1001 : 4'b0110) : 0;
            exp_ack = ((req_mode == 1 && t <= ACK) || (req_mode != 0 && t > fin)) ? 0 : 1;
            chk("R1 strobe", int'(stb_n), (t <= STB) ? 0 : 1);
            chk((extra && t > fin) ? "R10 busy after ignored pulse" : "R9 busy",
                int'(busy), (t <= fin) ? 1 : 0);
            chk(t <= ACK ? "R3 grace ack" : (t <= fin ? "R4 held-off ack" : "R8 ack after burst"),
                int'(ack_n), exp_ack);
            chk("R2 R6 R11 enables", en_bits(), exp_en);
            if (slot) begin
                chk("R5 buffer address", int'(baddr), m / W);
                chk("R5 RAM address", int'(raddr), m / W);
            end
            if (en_bits() != 0) seen++;
            msg_ok = extra && (t == STB + 1);
            wcount = ~AW'(wc);
            dir_rx = ~dir;
            if (req_mode == 2 && t == STB / 2) sub_req = 1'b1;
        end
        msg_ok = 1'b0;
        chk("R5 R11 word total", seen, n);
        sub_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset strobe", int'(stb_n), 1);
        chk("R9 reset ack", int'(ack_n), 1);
        chk("R9 reset busy", int'(busy), 0);
        chk("R9 reset enables", en_bits(), 0);

        // R8: idle acknowledge follows the request by one cycle
        sub_req = 1'b1;
        @(negedge clk);
        chk("R8 idle ack assert", int'(ack_n), 0);
        sub_req = 1'b0;
        @(negedge clk);
        chk("R8 idle ack release", int'(ack_n), 1);

        // R7: no validated pulse, so nothing moves
        for (int c = 0; c < 24; c++) begin
            wcount  = AW'(c);
            dir_rx  = c[0];
            sub_req = c[1];
            @(negedge clk);
            chk("R7 no strobe", int'(stb_n), 1);
            chk("R7 no busy", int'(busy), 0);
            chk("R7 no enables", en_bits(), 0);
        end
        sub_req = 1'b0;
        @(negedge clk);

        for (int wc = 0; wc < MAXW; wc++)
            for (int dr = 0; dr < 2; dr++)
                for (int rm = 0; rm < 3; rm++)
                    run_msg(wc, dr[0], rm, (wc + rm) % 2 == 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule